// File: doc/BRIEF.md
# ARINC 429 Serial Word Receiver

This block turns a return-to-zero ARINC 429 line, already translated into two logic rails (a "one" rail and a "zero" rail), into 32-bit words for a host with an 8-bit port. A sampling strobe runs at four times the bit rate. Each strobe samples the rails once. A bit is taken from the rail level and its length. Words are framed by the null gap that separates them. The host sets word mode to read a whole word as four bytes, or clears it to take each byte as soon as its eight bits arrive.

The receiver checks each word's framing and, when parity is enabled, its odd parity. It keeps sticky error bits for parity, overwrite and framing faults. A status-read strobe clears all three. While any error is pending, reception stops. A one-shot arm input hides the ready flag for the next word only. A self-test select takes the strobe and both rails from the local transmitter's loopback signals instead of the line.

Top module: `arx_word_receiver`

## Requirements
- R1: After reset, `rdy_o`, `first_o`, `err_par_o`, `err_ovr_o`, `err_frm_o` and `err_o` are all 0.
- R2: After reset, no bit is accepted until the rails have been null for 12 consecutive samples (three bit times). A word sent before that gap produces neither ready nor an error.
- R3: A bit is a one-rail (`one`=1, `zero`=0) or zero-rail (`one`=0, `zero`=1) level held for at least 2 samples and then followed by a null sample. A level held for only 1 sample is ignored. The first bit received becomes word bit 0.
- R4: In word mode (`word_mode_i`=1), `rdy_o` and `first_o` rise after the 32nd good bit. `dout_o` then shows byte 0 (word bits 7:0), and each `rd_data_i` pulse moves to the next higher byte. Byte 3 carries word bit 31, the parity bit, in its bit 7. After the fourth read, `rdy_o` and `first_o` fall.
- R5: In byte mode (`word_mode_i`=0), `rdy_o` rises after each group of 8 good bits, with that byte on `dout_o`. `first_o` is 1 for the first byte of a word and 0 for the others. One `rd_data_i` pulse clears `rdy_o`.
- R6: With `parity_en_i`=1, a word whose 32 bits hold an even number of ones sets `err_par_o` and is not made ready. With `parity_en_i`=0, bit 31 is plain data and no parity check is made.
- R7: A new word (or byte) that becomes ready while `rdy_o` is still 1 sets `err_ovr_o`. The new data replaces the old.
- R8: A gap of 12 null samples that ends a word of 1 to 31 bits sets `err_frm_o`.
- R9: A 33rd bit before the gap sets `err_frm_o`.
- R10: A sample with both rails high during a word sets `err_frm_o`.
- R11: The error bits are sticky. `err_o` is 1 while any of them is set. A `rd_status_i` pulse clears them all. While an error is pending, no word is received. Once the errors are cleared, the next word is taken after an idle line.
- R12: A `skip_arm_i` pulse keeps `rdy_o` low for the next word. It raises no overwrite, still sets `first_o`, and clears itself when that word completes.
- R13: With `self_test_i`=1, the strobe and rails come from `lb_tick_i`, `lb_one_i` and `lb_zero_i`, and the line inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| self_test_i | input | 1 | Take strobe and rails from the loopback inputs |
| rx_tick_i | input | 1 | Line sample strobe, four per bit |
| rx_one_i | input | 1 | Line "one" rail |
| rx_zero_i | input | 1 | Line "zero" rail |
| lb_tick_i | input | 1 | Loopback sample strobe from the transmitter |
| lb_one_i | input | 1 | Loopback "one" rail |
| lb_zero_i | input | 1 | Loopback "zero" rail |
| word_mode_i | input | 1 | 1: whole-word hand-over, 0: per-byte |
| parity_en_i | input | 1 | Enable the odd-parity check on bit 31 |
| skip_arm_i | input | 1 | Pulse: hide ready for the next word |
| rd_data_i | input | 1 | Pulse: host consumed the byte on `dout_o` |
| rd_status_i | input | 1 | Pulse: status read, clears the error bits |
| dout_o | output | 8 | Byte presented to the host |
| rdy_o | output | 1 | Received data ready |
| first_o | output | 1 | First byte of a word (byte mode) or valid word (word mode) |
| err_par_o | output | 1 | Sticky parity error |
| err_ovr_o | output | 1 | Sticky overwrite error |
| err_frm_o | output | 1 | Sticky framing error |
| err_o | output | 1 | Any error pending |

## Verification
A sampler whose run or null counter is off shows up on the next word. Either the word never becomes ready, or the bytes are shifted by a bit, or `err_frm_o` rises at the end of the gap. A bit counter that slips gives a false short or long framing error when the 12-sample gap ends. A bad read pointer, or a ready flag that clears too early, shows on `dout_o` or `rdy_o` at the very next `rd_data_i` pulse. Error flags that are not sticky, or a blocking path that does not hold reception, show when a good word sent while an error is pending still raises `rdy_o`.

// File: rtl/arx_pkg.sv
package arx_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NBYTES = WORD_W / BYTE_W;
  localparam int unsigned IDX_W  = $clog2(NBYTES);
  localparam int unsigned CNT_W  = $clog2(WORD_W + 1);
  localparam int unsigned BIX_W  = $clog2(BYTE_W);

  // rail pair encoding {one, zero}
  typedef enum logic [1:0] {
    LV_NULL  = 2'b00,
    LV_ZERO  = 2'b01,
    LV_ONE   = 2'b10,
    LV_CLASH = 2'b11
  } rail_lvl_e;

  // odd number of ones over the whole word
  function automatic logic weight_is_odd(input logic [WORD_W-1:0] w);
    return ^w;
  endfunction

  function automatic logic [BYTE_W-1:0] pick_byte(input logic [WORD_W-1:0] w,
                                                  input logic [IDX_W-1:0] idx);
    return w[int'(idx)*BYTE_W +: BYTE_W];
  endfunction
endpackage

// File: rtl/arx_line_sampler.sv
module arx_line_sampler
  import arx_pkg::*;
#(
  parameter int unsigned OSR      = 4,
  parameter int unsigned RUN_MIN  = 2,
  parameter int unsigned GAP_BITS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic self_test_i,
  input  logic ext_tick_i,
  input  logic ext_one_i,
  input  logic ext_zero_i,
  input  logic lb_tick_i,
  input  logic lb_one_i,
  input  logic lb_zero_i,
  output logic bit_stb_o,
  output logic bit_val_o,
  output logic gap_stb_o,
  output logic idle_o,
  output logic clash_stb_o
);
  localparam int unsigned GAP_SMP = GAP_BITS * OSR;
  localparam int unsigned RUN_W   = $clog2(OSR + 1);
  localparam int unsigned NUL_W   = $clog2(GAP_SMP + 1);

  logic             tick;
  rail_lvl_e        cur;
  rail_lvl_e        prev_q;
  logic [RUN_W-1:0] run_q;
  logic [NUL_W-1:0] nul_q;
  logic             prev_is_bit;

  always_comb begin
    tick        = self_test_i ? lb_tick_i : ext_tick_i;
    cur         = rail_lvl_e'(self_test_i ? {lb_one_i, lb_zero_i}
                                          : {ext_one_i, ext_zero_i});
    prev_is_bit = (prev_q == LV_ZERO) || (prev_q == LV_ONE);
    bit_stb_o   = tick && (cur == LV_NULL) && prev_is_bit
                  && (run_q >= RUN_W'(RUN_MIN));
    bit_val_o   = (prev_q == LV_ONE);
    gap_stb_o   = tick && (cur == LV_NULL) && (nul_q == NUL_W'(GAP_SMP - 1));
    idle_o      = (nul_q == NUL_W'(GAP_SMP));
    clash_stb_o = tick && (cur == LV_CLASH);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= LV_NULL;
      run_q  <= '0;
      nul_q  <= '0;
    end else if (tick) begin
      prev_q <= cur;
      if (cur == prev_q) begin
        if (run_q != RUN_W'(OSR)) run_q <= run_q + 1'b1;
      end else begin
        run_q <= RUN_W'(1);
      end
      if (cur == LV_NULL) begin
        if (nul_q != NUL_W'(GAP_SMP)) nul_q <= nul_q + 1'b1;
      end else begin
        nul_q <= '0;
      end
    end
  end
endmodule

// File: rtl/arx_bit_framer.sv
module arx_bit_framer
  import arx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_stb_i,
  input  logic              bit_val_i,
  input  logic              gap_stb_i,
  input  logic              idle_i,
  input  logic              clash_stb_i,
  input  logic              hold_off_i,
  output logic              synced_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              byte_stb_o,
  output logic              byte_first_o,
  output logic              word_stb_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic [WORD_W-1:0] word_o,
  output logic              frame_err_o
);
  logic              synced_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] sh_q;
  logic [WORD_W-1:0] nxt;
  logic              take, full, accept;
  logic              err_short, err_long, err_clash;

  always_comb begin
    nxt          = {bit_val_i, sh_q[WORD_W-1:1]};
    take         = bit_stb_i && synced_q && !hold_off_i;
    full         = (cnt_q == CNT_W'(WORD_W));
    accept       = take && !full;
    byte_stb_o   = accept && (cnt_q[BIX_W-1:0] == '1);
    byte_first_o = accept && (cnt_q == CNT_W'(BYTE_W - 1));
    word_stb_o   = accept && (cnt_q == CNT_W'(WORD_W - 1));
    byte_o       = nxt[WORD_W-1 -: BYTE_W];
    word_o       = nxt;
    err_short    = gap_stb_i && synced_q && !hold_off_i && (cnt_q != '0) && !full;
    err_long     = take && full;
    err_clash    = clash_stb_i && synced_q && !hold_off_i;
    frame_err_o  = err_short || err_long || err_clash;
    synced_o     = synced_q;
    cnt_o        = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      synced_q <= 1'b0;
      cnt_q    <= '0;
      sh_q     <= '0;
    end else if (hold_off_i || clash_stb_i || err_long) begin
      synced_q <= 1'b0;
      cnt_q    <= '0;
    end else if (gap_stb_i || idle_i) begin
      synced_q <= 1'b1;
      cnt_q    <= '0;
    end else if (accept) begin
      sh_q  <= nxt;
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/arx_host_port.sv
module arx_host_port
  import arx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              word_mode_i,
  input  logic              parity_en_i,
  input  logic              skip_arm_i,
  input  logic              rd_data_i,
  input  logic              rd_status_i,
  input  logic              byte_stb_i,
  input  logic              byte_first_i,
  input  logic              word_stb_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              frame_err_i,
  output logic [BYTE_W-1:0] dout_o,
  output logic              rdy_o,
  output logic              first_o,
  output logic              err_par_o,
  output logic              err_ovr_o,
  output logic              err_frm_o,
  output logic              err_o,
  output logic              deliver_o,
  output logic              skip_o
);
  logic [WORD_W-1:0] hold_q;
  logic [IDX_W-1:0]  ptr_q;
  logic              rdy_q, first_q, skip_q;
  logic              e_par_q, e_ovr_q, e_frm_q;
  logic              par_bad, word_bad, deliver;

  always_comb begin
    par_bad   = parity_en_i && !weight_is_odd(word_i);
    word_bad  = word_stb_i && par_bad;
    deliver   = word_mode_i ? (word_stb_i && !par_bad) : (byte_stb_i && !word_bad);
    dout_o    = pick_byte(hold_q, ptr_q);
    rdy_o     = rdy_q;
    first_o   = first_q;
    err_par_o = e_par_q;
    err_ovr_o = e_ovr_q;
    err_frm_o = e_frm_q;
    err_o     = e_par_q || e_ovr_q || e_frm_q;
    deliver_o = deliver;
    skip_o    = skip_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= '0;
      ptr_q   <= '0;
      rdy_q   <= 1'b0;
      first_q <= 1'b0;
      skip_q  <= 1'b0;
      e_par_q <= 1'b0;
      e_ovr_q <= 1'b0;
      e_frm_q <= 1'b0;
    end else begin
      if (rd_data_i && rdy_q) begin
        if (!word_mode_i || ptr_q == IDX_W'(NBYTES - 1)) begin
          rdy_q   <= 1'b0;
          first_q <= 1'b0;
          ptr_q   <= '0;
        end else begin
          ptr_q <= ptr_q + 1'b1;
        end
      end
      if (deliver) begin
        hold_q  <= word_mode_i ? word_i : WORD_W'(byte_i);
        ptr_q   <= '0;
        first_q <= word_mode_i || byte_first_i;
        if (!skip_q) rdy_q <= 1'b1;
      end
      if (word_stb_i) skip_q <= 1'b0;
      if (skip_arm_i) skip_q <= 1'b1;
      if (rd_status_i) begin
        e_par_q <= 1'b0;
        e_ovr_q <= 1'b0;
        e_frm_q <= 1'b0;
      end
      if (frame_err_i) e_frm_q <= 1'b1;
      if (word_bad) e_par_q <= 1'b1;
      if (deliver && rdy_q && !skip_q) e_ovr_q <= 1'b1;
    end
  end
endmodule

// File: rtl/arx_word_receiver.sv
module arx_word_receiver
  import arx_pkg::*;
#(
  parameter int unsigned OSR      = 4,
  parameter int unsigned RUN_MIN  = 2,
  parameter int unsigned GAP_BITS = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       self_test_i,
  input  logic       rx_tick_i,
  input  logic       rx_one_i,
  input  logic       rx_zero_i,
  input  logic       lb_tick_i,
  input  logic       lb_one_i,
  input  logic       lb_zero_i,
  input  logic       word_mode_i,
  input  logic       parity_en_i,
  input  logic       skip_arm_i,
  input  logic       rd_data_i,
  input  logic       rd_status_i,
  output logic [7:0] dout_o,
  output logic       rdy_o,
  output logic       first_o,
  output logic       err_par_o,
  output logic       err_ovr_o,
  output logic       err_frm_o,
  output logic       err_o
);
  logic              bit_stb, bit_val, gap_stb, idle, clash_stb;
  logic              synced;
  logic [CNT_W-1:0]  bit_cnt;
  logic              byte_stb, byte_first, word_stb, frame_err;
  logic [BYTE_W-1:0] byte_bus;
  logic [WORD_W-1:0] word_bus;
  logic              deliver, skip_pend;

  arx_line_sampler #(.OSR(OSR), .RUN_MIN(RUN_MIN), .GAP_BITS(GAP_BITS)) u_smp (
    .clk(clk), .rst(rst), .self_test_i(self_test_i),
    .ext_tick_i(rx_tick_i), .ext_one_i(rx_one_i), .ext_zero_i(rx_zero_i),
    .lb_tick_i(lb_tick_i), .lb_one_i(lb_one_i), .lb_zero_i(lb_zero_i),
    .bit_stb_o(bit_stb), .bit_val_o(bit_val), .gap_stb_o(gap_stb),
    .idle_o(idle), .clash_stb_o(clash_stb)
  );

  arx_bit_framer u_frm (
    .clk(clk), .rst(rst), .bit_stb_i(bit_stb), .bit_val_i(bit_val),
    .gap_stb_i(gap_stb), .idle_i(idle), .clash_stb_i(clash_stb),
    .hold_off_i(err_o), .synced_o(synced), .cnt_o(bit_cnt),
    .byte_stb_o(byte_stb), .byte_first_o(byte_first), .word_stb_o(word_stb),
    .byte_o(byte_bus), .word_o(word_bus), .frame_err_o(frame_err)
  );

  arx_host_port u_host (
    .clk(clk), .rst(rst), .word_mode_i(word_mode_i), .parity_en_i(parity_en_i),
    .skip_arm_i(skip_arm_i), .rd_data_i(rd_data_i), .rd_status_i(rd_status_i),
    .byte_stb_i(byte_stb), .byte_first_i(byte_first), .word_stb_i(word_stb),
    .byte_i(byte_bus), .word_i(word_bus), .frame_err_i(frame_err),
    .dout_o(dout_o), .rdy_o(rdy_o), .first_o(first_o),
    .err_par_o(err_par_o), .err_ovr_o(err_ovr_o), .err_frm_o(err_frm_o),
    .err_o(err_o), .deliver_o(deliver), .skip_o(skip_pend)
  );
endmodule

// File: rtl/arx_checker.sv
module arx_checker
  import arx_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             self_test_i,
  input logic             rx_tick_i,
  input logic             rx_one_i,
  input logic             rx_zero_i,
  input logic             word_mode_i,
  input logic             rd_status_i,
  input logic             rdy_o,
  input logic             first_o,
  input logic             err_o,
  input logic             err_ovr_o,
  input logic             err_frm_o,
  input logic             synced,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             byte_stb,
  input logic             word_stb,
  input logic             frame_err,
  input logic             deliver,
  input logic             skip_pend
);
  assert_word_first_R4: assert property (@(posedge clk) disable iff (rst)
    ($rose(rdy_o) && $past(word_mode_i)) |-> first_o);

  assert_overwrite_R7: assert property (@(posedge clk) disable iff (rst)
    (deliver && rdy_o && !skip_pend) |=> err_ovr_o);

  assert_count_bound_R9: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= CNT_W'(WORD_W));

  assert_clash_flags_R10: assert property (@(posedge clk) disable iff (rst)
    (!self_test_i && rx_tick_i && rx_one_i && rx_zero_i && synced && !err_o)
    |=> err_frm_o);

  assert_clear_on_read_R11: assert property (@(posedge clk) disable iff (rst)
    (rd_status_i && !frame_err && !byte_stb) |=> !err_o);

  assert_skip_holds_R12: assert property (@(posedge clk) disable iff (rst)
    (skip_pend && word_stb && !rdy_o) |=> !rdy_o);
endmodule

bind arx_word_receiver arx_checker u_arx_chk (
  .clk(clk), .rst(rst), .self_test_i(self_test_i), .rx_tick_i(rx_tick_i),
  .rx_one_i(rx_one_i), .rx_zero_i(rx_zero_i), .word_mode_i(word_mode_i),
  .rd_status_i(rd_status_i), .rdy_o(rdy_o), .first_o(first_o), .err_o(err_o),
  .err_ovr_o(err_ovr_o), .err_frm_o(err_frm_o), .synced(synced),
  .bit_cnt(bit_cnt), .byte_stb(byte_stb), .word_stb(word_stb),
  .frame_err(frame_err), .deliver(deliver), .skip_pend(skip_pend)
);

// File: tb/arx_word_receiver_tb.sv
module arx_word_receiver_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic self_test = 0, rx_tick = 0, rx_one = 0, rx_zero = 0;
  logic lb_tick = 0, lb_one = 0, lb_zero = 0;
  logic word_mode = 1, parity_en = 1, skip_arm = 0, rd_data = 0, rd_status = 0;
  logic [7:0] dout;
  logic rdy, first, e_par, e_ovr, e_frm, e_any;
  int checks = 0;
  int errors = 0;
  logic done = 0;

  always #4 clk = ~clk;

  arx_word_receiver u_dut (
    .clk(clk), .rst(rst), .self_test_i(self_test), .rx_tick_i(rx_tick),
    .rx_one_i(rx_one), .rx_zero_i(rx_zero), .lb_tick_i(lb_tick),
    .lb_one_i(lb_one), .lb_zero_i(lb_zero), .word_mode_i(word_mode),
    .parity_en_i(parity_en), .skip_arm_i(skip_arm), .rd_data_i(rd_data),
    .rd_status_i(rd_status), .dout_o(dout), .rdy_o(rdy), .first_o(first),
    .err_par_o(e_par), .err_ovr_o(e_ovr), .err_frm_o(e_frm), .err_o(e_any)
  );

  function automatic logic [31:0] odd_word(input logic [30:0] d);
    return {~(^d), d};
  endfunction

  task automatic expect_eq(input string req, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic samp(input logic one, input logic zero);
    @(negedge clk);
    if (self_test) begin
      lb_one = one; lb_zero = zero; lb_tick = 1;
      rx_one = 1; rx_zero = 1; rx_tick = 1;
    end else begin
      rx_one = one; rx_zero = zero; rx_tick = 1;
    end
    @(negedge clk);
    rx_tick = 0; lb_tick = 0;
  endtask

  task automatic send_bit(input logic b);
    samp(b, !b); samp(b, !b); samp(0, 0); samp(0, 0);
  endtask

  task automatic send_gap();
    repeat (14) samp(0, 0);
  endtask

  task automatic send_bits(input logic [31:0] w, input int n);
    for (int i = 0; i < n; i++) send_bit(w[i % 32]);
  endtask

  task automatic pulse_rd();
    @(negedge clk); rd_data = 1; @(negedge clk); rd_data = 0;
  endtask

  task automatic pulse_status();
    @(negedge clk); rd_status = 1; @(negedge clk); rd_status = 0;
  endtask

  task automatic read_word(input string req, input logic [31:0] w);
    for (int k = 0; k < 4; k++) begin
      expect_eq(req, "word byte", dout, w[8*k +: 8]);
      pulse_rd();
    end
    expect_eq(req, "rdy after 4 reads", rdy, 0);
    expect_eq(req, "first after 4 reads", first, 0);
  endtask

  task automatic t_reset();
    expect_eq("R1", "rdy", rdy, 0);
    expect_eq("R1", "first", first, 0);
    expect_eq("R1", "errors", {e_par, e_ovr, e_frm, e_any}, 0);
  endtask

  task automatic t_nosync();
    logic [31:0] w = odd_word(31'h1234_5678);
    send_bits(w, 32);
    expect_eq("R2", "rdy before gap", rdy, 0);
    expect_eq("R2", "err before gap", e_any, 0);
    send_gap();
    expect_eq("R2", "rdy after gap", rdy, 0);
  endtask

  task automatic t_word();
    logic [31:0] w = odd_word(31'h4A5B_C3D2);
    send_bits(w, 32);
    expect_eq("R4", "rdy", rdy, 1);
    expect_eq("R4", "first", first, 1);
    for (int k = 0; k < 3; k++) pulse_rd();
    expect_eq("R4", "parity bit in byte 3 bit 7", dout[7], w[31]);
    pulse_rd();
    expect_eq("R4", "rdy after reads", rdy, 0);
    send_gap();
    send_bits(w, 32);
    read_word("R4", w);
    send_gap();
  endtask

  task automatic t_glitch();
    logic [31:0] w = odd_word(31'h0F0F_5AA5);
    send_bits(w, 16);
    samp(1, 0); samp(0, 0); samp(0, 0);
    for (int i = 16; i < 32; i++) send_bit(w[i]);
    expect_eq("R3", "rdy with glitch", rdy, 1);
    expect_eq("R3", "no frame err", e_frm, 0);
    read_word("R3", w);
    send_gap();
  endtask

  task automatic t_byte();
    logic [31:0] w = odd_word(31'h3C69_E11B);
    word_mode = 0;
    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < 8; i++) send_bit(w[8*k + i]);
      expect_eq("R5", "rdy per byte", rdy, 1);
      expect_eq("R5", "first flag", first, (k == 0) ? 1 : 0);
      expect_eq("R5", "byte value", dout, w[8*k +: 8]);
      pulse_rd();
      expect_eq("R5", "rdy after read", rdy, 0);
    end
    expect_eq("R5", "no overwrite", e_ovr, 0);
    send_gap();
    word_mode = 1;
  endtask

  task automatic t_parity();
    logic [31:0] w = odd_word(31'h2468_ACE1) ^ 32'h8000_0000;
    send_bits(w, 32);
    expect_eq("R6", "rdy on even word", rdy, 0);
    expect_eq("R6", "parity err", e_par, 1);
    expect_eq("R11", "any err", e_any, 1);
    send_gap();
    pulse_status();
    expect_eq("R11", "cleared", {e_par, e_ovr, e_frm, e_any}, 0);
    parity_en = 0;
    send_bits(w, 32);
    expect_eq("R6", "rdy parity off", rdy, 1);
    expect_eq("R6", "no parity err when off", e_par, 0);
    read_word("R6", w);
    send_gap();
    parity_en = 1;
  endtask

  task automatic t_overwrite();
    logic [31:0] wa = odd_word(31'h1111_2222);
    logic [31:0] wb = odd_word(31'h5555_0A0A);
    send_bits(wa, 32); send_gap();
    send_bits(wb, 32); send_gap();
    expect_eq("R7", "overwrite err", e_ovr, 1);
    read_word("R7", wb);
    pulse_status();
    expect_eq("R7", "cleared", e_ovr, 0);
  endtask

  task automatic t_short();
    send_bits(odd_word(31'h7777_7777), 20);
    expect_eq("R8", "no err before gap", e_frm, 0);
    send_gap();
    expect_eq("R8", "short frame err", e_frm, 1);
    expect_eq("R8", "no rdy", rdy, 0);
    pulse_status();
  endtask

  task automatic t_long();
    logic [31:0] w = odd_word(31'h0123_4567);
    send_bits(w, 32);
    expect_eq("R9", "rdy at 32", rdy, 1);
    send_bit(1'b1);
    expect_eq("R9", "long frame err", e_frm, 1);
    read_word("R9", w);
    send_gap();
    pulse_status();
  endtask

  task automatic t_clash();
    send_bits(odd_word(31'h6543_210F), 10);
    samp(1, 1);
    expect_eq("R10", "clash err", e_frm, 1);
    send_gap();
    pulse_status();
    expect_eq("R10", "cleared", e_frm, 0);
  endtask

  task automatic t_block();
    logic [31:0] w = odd_word(31'h1E2D_3C4B);
    send_bits(w, 5); send_gap();
    expect_eq("R11", "frame err pending", e_frm, 1);
    send_bits(w, 32); send_gap();
    expect_eq("R11", "blocked no rdy", rdy, 0);
    expect_eq("R11", "sticky", e_frm, 1);
    pulse_status();
    expect_eq("R11", "cleared", e_any, 0);
    send_bits(w, 32);
    expect_eq("R11", "rdy after clear", rdy, 1);
    read_word("R11", w);
    send_gap();
  endtask

  task automatic t_skip();
    logic [31:0] wa = odd_word(31'h0BAD_F00D);
    logic [31:0] wb = odd_word(31'h3EED_BEEF);
    @(negedge clk); skip_arm = 1; @(negedge clk); skip_arm = 0;
    send_bits(wa, 32);
    expect_eq("R12", "rdy hidden", rdy, 0);
    expect_eq("R12", "first still set", first, 1);
    send_gap();
    send_bits(wb, 32);
    expect_eq("R12", "rdy on next word", rdy, 1);
    expect_eq("R12", "no overwrite", e_ovr, 0);
    read_word("R12", wb);
    send_gap();
  endtask

  task automatic t_selftest();
    logic [31:0] w = odd_word(31'h5A5A_1234);
    self_test = 1;
    send_bits(w, 32);
    expect_eq("R13", "loopback rdy", rdy, 1);
    expect_eq("R13", "line ignored", e_frm, 0);
    read_word("R13", w);
    send_gap();
    self_test = 0;
    rx_one = 0; rx_zero = 0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_nosync();
    t_word();
    t_glitch();
    t_byte();
    t_parity();
    t_overwrite();
    t_short();
    t_long();
    t_clash();
    t_block();
    t_skip();
    t_selftest();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule